// File: doc/BRIEF.md
# Host command stream parser

This block sits between a fetch engine that delivers 32-bit command words and a set of register-programmed engines. It reads the word stream on a valid/ready input and emits register write transactions on a valid/ready output. Each transaction carries the class ID of the currently selected engine, a 12-bit register offset and 32 bits of data.

A word is read as a header only when nothing is still owed to the previous header. The header's top nibble picks one of five submission forms. Class select switches the target engine and can pre-load a small write mask. The incrementing burst writes a run of consecutive registers. The non-incrementing burst writes one register repeatedly. The masked burst fills a sparse set of registers, lowest first. The immediate form carries its own 12-bit payload and triggers one write. The payload words after a header turn into writes at offsets derived from that header, whatever their top nibble holds.

The control is a three-state machine. ST_HDR decodes headers. It moves to ST_MASK when a class-select or mask header leaves a nonzero mask, and to ST_BURST when a burst header carries a nonzero count. Otherwise it stays in ST_HDR. ST_MASK consumes one payload word per set mask bit and returns to ST_HDR when the last bit clears. ST_BURST consumes one word per count and returns to ST_HDR when the count reaches zero. Reset forces ST_HDR.

Top module: `cmd_stream_parser`

## Requirements
- R1: A synchronous active-high reset empties the pending mask and count, sets the offset and the current class to 0, drops `wr_valid` and clears `err_sticky`. After reset, the next accepted word is decoded as a header.
- R2: A word is decoded as a header only when no mask bit is pending and the remaining count is zero. Its mode is bits 31:28, with the encodings 0 = class select, 1 = incrementing burst, 2 = non-incrementing burst, 3 = masked burst and 4 = immediate.
- R3: A class-select header loads the base offset from bits 27:16, the class ID from bits 15:6 and a 6-bit mask from bits 5:0. All later writes carry the new class ID.
- R4: While the mask is nonzero, each payload word is written to the base offset plus the index of the lowest set mask bit, modulo 4096, and that bit is then cleared.
- R5: An incrementing burst header takes the word count from bits 15:0 and the base offset from bits 27:16. Each payload write goes to the current offset, which then advances by one and wraps modulo 4096.
- R6: A non-incrementing burst header takes the same fields as R5, but every payload write goes to the same base offset.
- R7: A masked-burst header loads a 16-bit mask from bits 15:0 and the base offset from bits 27:16. The payload is then consumed as in R4.
- R8: An immediate header produces exactly one write to the offset in bits 27:16. Its data is bits 11:0 zero-extended to 32 bits, and no payload words follow it.
- R9: A burst header with a count of zero, or a class-select or masked-burst header with a mask of zero, produces no write, and the next word is a header.
- R10: A header whose mode is 5 to 15 is consumed without any write and sets `err_sticky`, which stays high until reset.
- R11: While `wr_valid` is high and `wr_ready` is low, the write outputs hold steady and `in_ready` is low, so no input word is lost.
- R12: A pending mask takes precedence over a pending count. Payload words are never decoded as headers, even when their top nibble is a valid mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word valid |
| in_word | input | 32 | Command word |
| in_ready | output | 1 | Command word accepted when high with in_valid |
| wr_valid | output | 1 | Write transaction valid |
| wr_ready | input | 1 | Downstream accepts the write |
| wr_class | output | 10 | Class ID of the write |
| wr_offset | output | 12 | Register offset of the write |
| wr_data | output | 32 | Write data |
| err_sticky | output | 1 | Set by an undefined mode, held until reset |

## Verification
The bench builds the block with its default field widths. These are a 16-bit mask register and a 16-bit count, with a 12-bit offset and a 10-bit class. With these widths a masked header can reach mask index 15, a bit set at the top of the mask. A burst started at offset 0xFFF crosses the 4096 wrap, and a class ID of 0x3FF fills the whole class field. Downstream ready follows a stalling pattern during the vector run, so writes are emitted under back-pressure. A directed case then holds ready low for several cycles.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
    localparam int WORD_W    = 32;
    localparam int OFF_W     = 12;
    localparam int CLASS_W   = 10;
    localparam int CMASK_W   = 6;
    localparam int MASK_W    = 16;
    localparam int CNT_W     = 16;
    localparam int IMM_W     = 12;
    localparam int MODE_W    = 4;
    localparam int MODE_LSB  = WORD_W - MODE_W;
    localparam int OFF_LSB   = 16;
    localparam int CLASS_LSB = CMASK_W;
    localparam int IDX_W     = $clog2(MASK_W);

    typedef enum logic [MODE_W-1:0] {
        MODE_CLASS  = 4'd0,
        MODE_INC    = 4'd1,
        MODE_NONINC = 4'd2,
        MODE_MASK   = 4'd3,
        MODE_IMM    = 4'd4
    } mode_e;

    typedef enum logic [1:0] {
        ST_HDR,
        ST_MASK,
        ST_BURST
    } st_e;

    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [OFF_W-1:0]   off;
        logic [CLASS_W-1:0] cls;
        logic [CMASK_W-1:0] cmask;
        logic [MASK_W-1:0]  mask;
        logic [CNT_W-1:0]   cnt;
        logic [IMM_W-1:0]   imm;
    } hdr_t;
endpackage

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
    import cmdp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              fields
);
    always_comb begin
        fields.mode  = word[MODE_LSB +: MODE_W];
        fields.off   = word[OFF_LSB +: OFF_W];
        fields.cls   = word[CLASS_LSB +: CLASS_W];
        fields.cmask = word[0 +: CMASK_W];
        fields.mask  = word[0 +: MASK_W];
        fields.cnt   = word[0 +: CNT_W];
        fields.imm   = word[0 +: IMM_W];
    end
endmodule

// File: rtl/cmdp_low_bit.sv
module cmdp_low_bit #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  pick
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = i[IW-1:0];
        end
    end

    assign pick = vec & (~vec + W'(1));
endmodule

// File: rtl/cmd_stream_parser.sv
module cmd_stream_parser
    import cmdp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_word,
    output logic                in_ready,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [CLASS_W-1:0]  wr_class,
    output logic [OFF_W-1:0]    wr_offset,
    output logic [WORD_W-1:0]   wr_data,
    output logic                err_sticky
);
    st_e                state_q, state_d;
    logic [MASK_W-1:0]  mask_q, mask_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [OFF_W-1:0]   off_q, off_d;
    logic [CLASS_W-1:0] cls_q, cls_d;
    logic               inc_q, inc_d;
    logic               err_d;

    logic               accept;
    logic               emit;
    logic [OFF_W-1:0]   emit_off;
    logic [WORD_W-1:0]  emit_data;
    hdr_t               hdr;
    logic [IDX_W-1:0]   low_idx;
    logic [MASK_W-1:0]  low_pick;
    logic [MASK_W-1:0]  mask_left;

    cmdp_hdr_decode u_dec (
        .word   (in_word),
        .fields (hdr)
    );

    cmdp_low_bit #(.W(MASK_W), .IW(IDX_W)) u_low (
        .vec  (mask_q),
        .idx  (low_idx),
        .pick (low_pick)
    );

    assign in_ready  = !wr_valid || wr_ready;
    assign accept    = in_valid && in_ready;
    assign mask_left = mask_q & ~low_pick;

    // Next-state and context logic
    always_comb begin
        state_d   = state_q;
        mask_d    = mask_q;
        cnt_d     = cnt_q;
        off_d     = off_q;
        cls_d     = cls_q;
        inc_d     = inc_q;
        err_d     = err_sticky;
        emit      = 1'b0;
        emit_off  = off_q;
        emit_data = in_word;
        if (accept) begin
            unique case (state_q)
                ST_HDR: begin
                    unique case (hdr.mode)
                        MODE_CLASS: begin
                            cls_d   = hdr.cls;
                            off_d   = hdr.off;
                            mask_d  = MASK_W'(hdr.cmask);
                            state_d = (hdr.cmask != '0) ? ST_MASK : ST_HDR;
                        end
                        MODE_INC, MODE_NONINC: begin
                            cnt_d   = hdr.cnt;
                            off_d   = hdr.off;
                            inc_d   = (hdr.mode == MODE_INC);
                            state_d = (hdr.cnt != '0) ? ST_BURST : ST_HDR;
                        end
                        MODE_MASK: begin
                            mask_d  = hdr.mask;
                            off_d   = hdr.off;
                            state_d = (hdr.mask != '0) ? ST_MASK : ST_HDR;
                        end
                        MODE_IMM: begin
                            off_d     = hdr.off;
                            emit      = 1'b1;
                            emit_off  = hdr.off;
                            emit_data = WORD_W'(hdr.imm);
                        end
                        default: err_d = 1'b1;
                    endcase
                end
                ST_MASK: begin
                    emit     = 1'b1;
                    emit_off = off_q + OFF_W'(low_idx);
                    mask_d   = mask_left;
                    if (mask_left == '0)
                        state_d = (cnt_q != '0) ? ST_BURST : ST_HDR;
                end
                ST_BURST: begin
                    emit     = 1'b1;
                    emit_off = off_q;
                    cnt_d    = cnt_q - CNT_W'(1);
                    if (inc_q) off_d = off_q + OFF_W'(1);
                    if (cnt_q == CNT_W'(1)) state_d = ST_HDR;
                end
                default: state_d = ST_HDR;
            endcase
        end
    end

    // State register and parser context
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_HDR;
            mask_q     <= '0;
            cnt_q      <= '0;
            off_q      <= '0;
            cls_q      <= '0;
            inc_q      <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            state_q    <= state_d;
            mask_q     <= mask_d;
            cnt_q      <= cnt_d;
            off_q      <= off_d;
            cls_q      <= cls_d;
            inc_q      <= inc_d;
            err_sticky <= err_d;
        end
    end

    // Output write port
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid  <= 1'b0;
            wr_class  <= '0;
            wr_offset <= '0;
            wr_data   <= '0;
        end else begin
            if (wr_valid && wr_ready) wr_valid <= 1'b0;
            if (emit) begin
                wr_valid  <= 1'b1;
                wr_class  <= cls_q;
                wr_offset <= emit_off;
                wr_data   <= emit_data;
            end
        end
    end

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_offset) &&
                                     $stable(wr_data) && $stable(wr_class)));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

    assert_mask_live_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MASK) |-> (mask_q != '0));

    assert_burst_live_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BURST) |-> (cnt_q != '0));

    assert_imm_zext_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && state_q == ST_HDR && hdr.mode == MODE_IMM) |=>
            (wr_valid && wr_data[WORD_W-1:IMM_W] == '0));
endmodule

// File: tb/sim_cmd_stream_parser.sv
module sim_cmd_stream_parser;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 30;
    localparam int NEXP = 21;

    // Input words; comments name the requirement each one drives
    localparam logic [31:0] VEC [NVEC] = '{
        32'h00100845,                // R3 class 0x21, off 0x010, mask 0b000101
        32'hAAAA0001, 32'hAAAA0002,  // R4 payload
        32'h10FF0003,                // R5 incrementing, off 0x0FF, count 3
        32'h11111111, 32'h22222222, 32'h33333333,
        32'h20400002,                // R6 non-incrementing, off 0x040, count 2
        32'h44444444, 32'h55555555,
        32'h32008001,                // R7 mask 0x8001, off 0x200
        32'h66666666, 32'h77777777,
        32'h4333FABC,                // R8 immediate
        32'h7FFFFFFF,                // R10 undefined mode 7
        32'h40010123,                // R8 immediate
        32'h10500000,                // R9 zero count
        32'h40020005,                // R9 next word is a header
        32'h1FFF0002,                // R5 wrap at 0xFFF
        32'h88888888, 32'h99999999,
        32'h0007FFC0,                // R9/R3 class 0x3FF, mask 0
        32'h4ABC0001,                // R8 immediate under new class
        32'h0100017F,                // R12 class 0x005, off 0x100, mask 0x3F
        32'h40000000, 32'h40000001, 32'h40000002,
        32'h40000003, 32'h40000004, 32'h40000005
    };

    // Expected writes {class[9:0], offset[11:0], data[31:0]}
    localparam logic [53:0] EXP [NEXP] = '{
        {10'h021, 12'h010, 32'hAAAA0001},
        {10'h021, 12'h012, 32'hAAAA0002},
        {10'h021, 12'h0FF, 32'h11111111},
        {10'h021, 12'h100, 32'h22222222},
        {10'h021, 12'h101, 32'h33333333},
        {10'h021, 12'h040, 32'h44444444},
        {10'h021, 12'h040, 32'h55555555},
        {10'h021, 12'h200, 32'h66666666},
        {10'h021, 12'h20F, 32'h77777777},
        {10'h021, 12'h333, 32'h00000ABC},
        {10'h021, 12'h001, 32'h00000123},
        {10'h021, 12'h002, 32'h00000005},
        {10'h021, 12'hFFF, 32'h88888888},
        {10'h021, 12'h000, 32'h99999999},
        {10'h3FF, 12'hABC, 32'h00000001},
        {10'h005, 12'h100, 32'h40000000},
        {10'h005, 12'h101, 32'h40000001},
        {10'h005, 12'h102, 32'h40000002},
        {10'h005, 12'h103, 32'h40000003},
        {10'h005, 12'h104, 32'h40000004},
        {10'h005, 12'h105, 32'h40000005}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [9:0]  wr_class;
    logic [11:0] wr_offset;
    logic [31:0] wr_data;
    logic        err_sticky;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int n_got = 0;
    logic [53:0] got [64];

    cmd_stream_parser u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .in_ready   (in_ready),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_class   (wr_class),
        .wr_offset  (wr_offset),
        .wr_data    (wr_data),
        .err_sticky (err_sticky)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Downstream ready pattern, changed just after each rising edge
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        case (rdy_mode)
            1:       wr_ready = (cyc % 3) != 0;
            2:       wr_ready = 1'b0;
            default: wr_ready = 1'b1;
        endcase
    end

    // Write monitor: handshake seen at the falling edge completes at the next rise
    always @(negedge clk) begin
        if (!rst && wr_valid && wr_ready && n_got < 64) begin
            got[n_got] = {wr_class, wr_offset, wr_data};
            n_got = n_got + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        in_valid = 1'b1;
        in_word  = w;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 5000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(wr_valid == 1'b0, "R1 wr_valid after reset", 64'(wr_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 1);
        check(err_sticky == 1'b0, "R1 err after reset", 64'(err_sticky), 0);
        @(posedge clk);
        #1;

        // Vector run under a stalling downstream
        rdy_mode = 1;
        for (int i = 0; i < NVEC; i++) send_word(VEC[i]);
        rdy_mode = 0;
        repeat (6) @(posedge clk);
        #1;
        check(n_got == NEXP, "R2 write count", 64'(n_got), 64'(NEXP));
        for (int i = 0; i < NEXP; i++) begin
            check(got[i] == EXP[i], "R2-table write (R3 R4 R5 R6 R7 R8 R9 R12)",
                  64'(got[i]), 64'(EXP[i]));
        end
        check(err_sticky == 1'b1, "R10 err after undefined mode", 64'(err_sticky), 1);

        // R11: hold under back-pressure
        rdy_mode = 2;
        @(posedge clk);
        #1;
        send_word(32'h40550077);
        repeat (3) @(posedge clk);
        #1;
        check(wr_valid == 1'b1, "R11 wr_valid held", 64'(wr_valid), 1);
        check(in_ready == 1'b0, "R11 in_ready low", 64'(in_ready), 0);
        check(wr_offset == 12'h055 && wr_data == 32'h77, "R11 write held",
              64'({wr_offset, wr_data}), 64'({12'h055, 32'h77}));
        rdy_mode = 0;
        repeat (2) @(posedge clk);
        #1;
        check(wr_valid == 1'b0, "R11 drained", 64'(wr_valid), 0);

        // R1: reset in the middle of a mask fill
        send_word(32'h00030A83);
        send_word(32'hDEAD0000);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        check(wr_valid == 1'b0, "R1 wr_valid after mid reset", 64'(wr_valid), 0);
        check(err_sticky == 1'b0, "R1 err cleared by reset", 64'(err_sticky), 0);
        send_word(32'h40070009);
        check(wr_valid == 1'b1 && wr_class == 10'h000 && wr_offset == 12'h007 &&
              wr_data == 32'h9, "R1 header decode and class 0 after reset",
              64'({wr_class, wr_offset, wr_data}), 64'({10'h0, 12'h007, 32'h9}));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule